// File: doc/BRIEF.md
# Chainable Transition Pulse Generator

This block drives one output line through a programmed number of level changes. It makes exactly one change per base period, and the base period is a programmed number of clock cycles. A down-counting base timer runs for as long as the enable input is high. It reloads from the period register each time it expires, so every output change lands on a fixed grid of period boundaries.

Both the period and the transition count are held in pending registers. A new period value changes nothing until the running period expires and the timer reloads. A non-zero count written while a segment is still running waits behind that segment, then starts at the boundary after the segment's last transition. Software can therefore chain segments back to back with no gap and no extra period.

Dropping the enable input restarts the base timer and returns the output to its idle level. It is the only way to move the period grid. Completion of a segment is reported by a one-cycle pulse and by a sticky flag.

Top module: `trans_pulse_gen`

## Requirements
- R1: With period register value P (P >= 2), the first output change comes P cycles after enable rises, with a count already loaded. Each later change follows the previous one by exactly P cycles.
- R2: A segment produces exactly the number of output changes that was written. After the last one the output keeps its level while the timer keeps running.
- R3: A period value written in the middle of a base period does not shorten or stretch that period. It takes effect only from the next timer reload.
- R4: A non-zero count written while a segment is running is queued. Its first change comes one period after the running segment's last change, with no gap. A write in the same cycle as that last change is also accepted.
- R5: While enable is low, the output is forced to its idle level and the remaining count is cleared. The timer is reloaded, so the first change after enable rises again comes P cycles later.
- R6: The done pulse is high for exactly the one cycle in which a segment's final output change appears. The sticky done flag is set by that event and cleared by any count write. If both happen in the same cycle, the set wins.
- R7: Writing a count of zero cancels any queued count and clears the done flag. The output then makes no further change.
- R8: After reset the output is at its idle level, and both the done pulse and the done flag are low.
- R9: A period value of 0 or 1 gives one output change on every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low restarts the base timer and idles the output |
| per_wr | input | 1 | Period register write strobe |
| per_data | input | PER_W | Base period in clock cycles |
| cnt_wr | input | 1 | Transition count write strobe |
| cnt_data | input | CNT_W | Number of output changes for the next segment |
| pin_out | output | 1 | Generated output line |
| done_pulse | output | 1 | One-cycle pulse with the final change of a segment |
| done_flag | output | 1 | Sticky completion flag, cleared by a count write |

## Verification
The final output change of a segment and a count write can fall in the same clock edge. That one edge both finishes the old segment and queues the next, and it both sets and clears the done flag. The bench provokes this by issuing the count write so that it is taken on the edge of the last change. It then judges the result from the output: the next segment's first change must come exactly one period later. The done flag must also read high right after that edge. A second check moves a period write into the middle of a running period and confirms that the old period still completes at full length.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

   // Timer reload value for a requested period; periods below 2 collapse to 0.
   function automatic logic [31:0] reload_of(input logic [31:0] period);
      return (period <= 32'd1) ? 32'd0 : period - 32'd1;
   endfunction

   // Outcome of one boundary for the segment counter
   typedef enum logic [1:0] {
      STEP_NONE  = 2'd0,
      STEP_RUN   = 2'd1,
      STEP_LOAD  = 2'd2
   } step_e;

endpackage

// File: rtl/tpg_base_timer.sv
module tpg_base_timer
   import tpg_pkg::*;
#(
   parameter int unsigned PER_W      = 16,
   parameter int unsigned DEF_PERIOD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             per_wr,
   input  logic [PER_W-1:0] per_data,
   output logic             expire
);
   localparam logic [PER_W-1:0] DEF_P   = PER_W'(DEF_PERIOD);
   localparam logic [PER_W-1:0] DEF_RLD = PER_W'(reload_of(32'(DEF_PERIOD)));

   logic [PER_W-1:0] per_pend;
   logic [PER_W-1:0] tmr;
   logic [PER_W-1:0] reload;

   always_comb begin
      reload = PER_W'(reload_of(32'(per_pend)));
      expire = enable && (tmr == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_pend <= DEF_P;
         tmr      <= DEF_RLD;
      end else begin
         if (per_wr)
            per_pend <= per_data;
         if (!enable || tmr == '0)
            tmr <= reload;
         else
            tmr <= tmr - 1'b1;
      end
   end
endmodule

// File: rtl/tpg_seg_counter.sv
module tpg_seg_counter
   import tpg_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             expire,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_data,
   output logic             level,
   output logic             done_pulse,
   output logic             done_flag
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] rem, rem_n;
   logic [CNT_W-1:0] pend, pend_n;
   logic             vld, vld_n;
   logic             lvl_n, done_n, flag_n;
   step_e            step;

   always_comb begin
      step = STEP_NONE;
      if (enable && expire) begin
         if (rem != '0)
            step = STEP_RUN;
         else if (vld)
            step = STEP_LOAD;
      end
   end

   always_comb begin
      rem_n  = rem;
      pend_n = pend;
      vld_n  = vld;
      lvl_n  = level;
      done_n = 1'b0;
      if (!enable) begin
         rem_n = '0;
         lvl_n = 1'b0;
      end else begin
         case (step)
            STEP_RUN: begin
               lvl_n  = ~level;
               rem_n  = rem - ONE;
               done_n = (rem == ONE);
            end
            STEP_LOAD: begin
               lvl_n  = ~level;
               rem_n  = pend - ONE;
               vld_n  = 1'b0;
               done_n = (pend == ONE);
            end
            default: ;
         endcase
      end
      if (cnt_wr) begin
         pend_n = cnt_data;
         vld_n  = (cnt_data != '0);
      end
      flag_n = done_n ? 1'b1 : (cnt_wr ? 1'b0 : done_flag);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem        <= '0;
         pend       <= '0;
         vld        <= 1'b0;
         level      <= 1'b0;
         done_pulse <= 1'b0;
         done_flag  <= 1'b0;
      end else begin
         rem        <= rem_n;
         pend       <= pend_n;
         vld        <= vld_n;
         level      <= lvl_n;
         done_pulse <= done_n;
         done_flag  <= flag_n;
      end
   end
endmodule

// File: rtl/trans_pulse_gen.sv
module trans_pulse_gen
   import tpg_pkg::*;
#(
   parameter int unsigned PER_W      = 16,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned DEF_PERIOD = 4,
   parameter bit          IDLE_HIGH  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             per_wr,
   input  logic [PER_W-1:0] per_data,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_data,
   output logic             pin_out,
   output logic             done_pulse,
   output logic             done_flag
);
   generate
      if (PER_W < 2 || PER_W > 32) begin : g_bad_per_w
         $error("trans_pulse_gen: PER_W must be within 2..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("trans_pulse_gen: CNT_W must be within 1..32");
      end
      if (DEF_PERIOD < 1 || DEF_PERIOD >= (64'd1 << PER_W)) begin : g_bad_def
         $error("trans_pulse_gen: DEF_PERIOD must fit PER_W and be non-zero");
      end
   endgenerate

   logic expire;
   logic level;

   tpg_base_timer #(
      .PER_W      (PER_W),
      .DEF_PERIOD (DEF_PERIOD)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .per_wr   (per_wr),
      .per_data (per_data),
      .expire   (expire)
   );

   tpg_seg_counter #(
      .CNT_W (CNT_W)
   ) u_seg (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .expire     (expire),
      .cnt_wr     (cnt_wr),
      .cnt_data   (cnt_data),
      .level      (level),
      .done_pulse (done_pulse),
      .done_flag  (done_flag)
   );

   generate
      if (IDLE_HIGH) begin : g_idle_high
         assign pin_out = ~level;
      end else begin : g_idle_low
         assign pin_out = level;
      end
   endgenerate
endmodule

// File: rtl/trans_pulse_gen_chk.sv
module trans_pulse_gen_chk #(
   parameter bit IDLE_HIGH = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic cnt_wr,
   input logic pin_out,
   input logic done_pulse,
   input logic done_flag
);
   // R6
   done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (pin_out != $past(pin_out)));

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> done_flag);

   // R6
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (done_flag == done_pulse));

   // R5
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (pin_out == IDLE_HIGH && !done_pulse));

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse && enable && $past(enable) |-> !$past(done_pulse) || pin_out != $past(pin_out));
endmodule

bind trans_pulse_gen trans_pulse_gen_chk #(
   .IDLE_HIGH (IDLE_HIGH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .cnt_wr     (cnt_wr),
   .pin_out    (pin_out),
   .done_pulse (done_pulse),
   .done_flag  (done_flag)
);

// File: tb/trans_pulse_gen_bench.sv
module trans_pulse_gen_bench;
   localparam int PER_W = 16;
   localparam int CNT_W = 16;
   // rows: written period, written count, effective period
   localparam int VEC [5][3] = '{
      '{3, 2, 3},
      '{4, 3, 4},
      '{1, 4, 1},
      '{6, 1, 6},
      '{0, 3, 1}
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             enable;
   logic             per_wr;
   logic [PER_W-1:0] per_data;
   logic             cnt_wr;
   logic [CNT_W-1:0] cnt_data;
   logic             pin_out;
   logic             done_pulse;
   logic             done_flag;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int base = 0;
   bit log_en = 1'b0;
   logic prev;
   int ntog, nd;
   int tog [32];
   int dn [8];
   bit finished = 1'b0;

   always #5 clk = ~clk;

   trans_pulse_gen #(.PER_W(PER_W), .CNT_W(CNT_W)) u_trans_pulse_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .per_wr(per_wr), .per_data(per_data),
      .cnt_wr(cnt_wr), .cnt_data(cnt_data),
      .pin_out(pin_out), .done_pulse(done_pulse), .done_flag(done_flag)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (log_en && (cyc - base) > 0) begin
         if (pin_out !== prev) begin
            if (ntog < 32) tog[ntog] = cyc - base;
            ntog++;
         end
         prev = pin_out;
         if (done_pulse) begin
            if (nd < 8) dn[nd] = cyc - base;
            nd++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic start_log();
      ntog = 0;
      nd = 0;
      prev = pin_out;
      base = cyc;
      log_en = 1'b1;
   endtask

   task automatic cyc_wait(input int k);
      while (cyc - base < k) @(negedge clk);
   endtask

   task automatic program_seg(input int p, input int y);
      @(negedge clk);
      enable = 1'b0;
      per_wr = 1'b1; per_data = PER_W'(p);
      cnt_wr = 1'b1; cnt_data = CNT_W'(y);
      @(negedge clk);
      per_wr = 1'b0; cnt_wr = 1'b0;
      @(negedge clk);
      @(negedge clk);
      enable = 1'b1;
      start_log();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; enable = 1'b0;
      per_wr = 1'b0; per_data = '0;
      cnt_wr = 1'b0; cnt_data = '0;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(pin_out == 1'b0, "R8 pin idle", int'(pin_out), 0);
      chk(done_pulse == 1'b0, "R8 done pulse", int'(done_pulse), 0);
      chk(done_flag == 1'b0, "R8 done flag", int'(done_flag), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R6 R9: table of segments
      for (int v = 0; v < 5; v++) begin
         int p, y;
         p = VEC[v][2];
         y = VEC[v][1];
         program_seg(VEC[v][0], y);
         cyc_wait(y * p + 2 * p + 2);
         chk(ntog == y, "R2 change count", ntog, y);
         chk(tog[0] == p, (p == 1) ? "R9 first change" : "R1 first change", tog[0], p);
         chk(tog[y-1] == y * p, (p == 1) ? "R9 last change" : "R1 last change", tog[y-1], y * p);
         chk(nd == 1 && dn[0] == y * p, "R6 done pulse timing", dn[0], y * p);
         chk(done_flag == 1'b1, "R6 flag set", int'(done_flag), 1);
      end

      // R4: count written on the edge of the last change
      program_seg(5, 2);
      cyc_wait(9);
      cnt_wr = 1'b1; cnt_data = CNT_W'(3);
      @(negedge clk);
      cnt_wr = 1'b0;
      chk(done_flag == 1'b1, "R6 set wins over write", int'(done_flag), 1);
      cyc_wait(32);
      chk(ntog == 5, "R4 chained change count", ntog, 5);
      chk(tog[2] == 15, "R4 no gap", tog[2], 15);
      chk(tog[4] == 25, "R4 chained end", tog[4], 25);
      chk(nd == 2 && dn[1] == 25, "R6 second done", dn[1], 25);

      // R7: zero count write
      @(negedge clk);
      cnt_wr = 1'b1; cnt_data = '0;
      @(negedge clk);
      cnt_wr = 1'b0;
      chk(done_flag == 1'b0, "R7 flag cleared", int'(done_flag), 0);
      start_log();
      cyc_wait(16);
      chk(ntog == 0, "R7 no change", ntog, 0);

      // R3: period write mid-period
      program_seg(5, 4);
      cyc_wait(12);
      per_wr = 1'b1; per_data = PER_W'(3);
      @(negedge clk);
      per_wr = 1'b0;
      cyc_wait(24);
      chk(tog[2] == 15, "R3 old period completes", tog[2], 15);
      chk(tog[3] == 18, "R3 new period applies", tog[3], 18);

      // R5: enable drop restarts the timer
      program_seg(5, 4);
      cyc_wait(7);
      enable = 1'b0;
      cnt_wr = 1'b1; cnt_data = CNT_W'(2);
      @(negedge clk);
      cnt_wr = 1'b0;
      chk(pin_out == 1'b0, "R5 idle when disabled", int'(pin_out), 0);
      enable = 1'b1;
      start_log();
      cyc_wait(16);
      chk(ntog == 2, "R5 remaining cleared", ntog, 2);
      chk(tog[0] == 5, "R5 timer restart", tog[0], 5);
      chk(tog[1] == 10, "R5 second change", tog[1], 10);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule